// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes the byte commands that a host writes into a parallel NOR-style flash device and runs the write-state controller behind them. Each bus write carries a command byte and a block address. The controller pairs two-cycle sequences, one for block erase and one for lock configuration. It lets a running erase be paused and resumed. It keeps a status byte with sticky error flags. It also holds a per-block table that records lock state and an erased flag.

No array is modelled. An erase is a countdown of `ERASE_CYCLES` clock cycles, and at the end of it the target block is marked as erased. A query port reports the lock state and erased flag of any block, and the status byte is always visible on its own output. A mode output tells the surrounding read path whether reads should return status or array data.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the status byte is 0x80. The read mode is array (`rd_status_mode`=0). Every block reads as locked (code 1) and not erased.
- R2: Lock configuration takes two writes: 0x60, then a second byte on the target block. A second byte of 0x01 locks the block, 0xD0 unlocks it and 0x2F locks it down. `q_lock` reports the lock state as 0 for unlocked, 1 for locked and 2 for locked-down.
- R3: Once a block is locked-down, a lock-configuration write cannot change it, and an unlock leaves it at code 2. Only reset clears it.
- R4: After 0x60, a second byte that is not 0x01, 0xD0 or 0x2F sets status bits 5 and 4 (status 0xB0) and leaves the lock table unchanged.
- R5: The write sequence 0x20 then 0xD0 starts an erase on an unlocked block. The target is the block addressed by the 0xD0 write. Status bit 7 reads 0 for exactly `ERASE_CYCLES` cycles after the confirm edge and then returns to 1. At that point the block's erased flag is set.
- R6: After 0x20, any second byte other than 0xD0 sets status bits 5 and 4, starts no erase and selects status read mode.
- R7: A confirm aimed at a block that is locked or locked-down starts no erase. It sets status bits 5 and 1 (status 0xA2).
- R8: While an erase is active, only 0xB0 and 0x70 are acted on. Lock-configuration writes and 0xFF have no effect.
- R9: A write of 0xB0 to any address during an erase suspends it, and the status byte becomes 0xC0. While suspended, the controller ignores erase and lock sequences, and the countdown holds.
- R10: A write of 0xD0 while suspended resumes the erase. Status bits 7 and 6 clear, and the erase finishes after exactly the number of cycles that remained.
- R11: Error bits 5, 4 and 1 stay set until a 0x50 write clears them. A 0x70 write does not clear them.
- R12: When idle, 0xFF selects array read mode, and 0x70, 0x20 and 0x60 select status read mode.
- R13: Reset during a suspended erase ends it. The status byte returns to 0x80 and every block, locked-down ones included, returns to locked.
- R14: A 0xB0 write while no erase is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_cmd | input | 8 | Command byte of the write |
| wr_blk | input | BLK_W | Block address of the write |
| q_blk | input | BLK_W | Block selected on the query port |
| status | output | 8 | Status byte: 7 ready, 6 erase suspended, 5 erase error, 4 sequence error, 1 block-locked error |
| rd_status_mode | output | 1 | 1 when reads should return status, 0 for array |
| q_lock | output | 2 | Lock state of `q_blk` (0 unlocked, 1 locked, 2 locked-down) |
| q_erased | output | 1 | Erased flag of `q_blk` |

## Verification
The bench targets a lock-down that an unlock quietly clears, and an erase whose target is the setup block rather than the confirm block. Either fault shows up directly on the query port. It also checks that the countdown stays frozen through a suspend and through commands ignored while suspended. A design that kept counting, or that restarted the count on resume, would go ready at the wrong cycle. It checks that lock commands slipped in during an erase change nothing, and that error bits survive a status read. A reset in the middle of a suspend must leave no leftover lock-down or suspend state.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
    localparam logic [7:0] OP_CONFIRM     = 8'hD0;
    localparam logic [7:0] OP_SUSPEND     = 8'hB0;
    localparam logic [7:0] OP_LOCK_SETUP  = 8'h60;
    localparam logic [7:0] OP_LOCK        = 8'h01;
    localparam logic [7:0] OP_LOCKDOWN    = 8'h2F;
    localparam logic [7:0] OP_CLR_STATUS  = 8'h50;
    localparam logic [7:0] OP_RD_STATUS   = 8'h70;
    localparam logic [7:0] OP_RD_ARRAY    = 8'hFF;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_ERASE_SETUP,
        CMD_CONFIRM,
        CMD_SUSPEND,
        CMD_LOCK_SETUP,
        CMD_LOCK,
        CMD_LOCKDOWN,
        CMD_CLR_STATUS,
        CMD_RD_STATUS,
        CMD_RD_ARRAY,
        CMD_OTHER
    } cmd_e;

    typedef enum logic [1:0] {
        BLK_UNLOCKED    = 2'd0,
        BLK_LOCKED      = 2'd1,
        BLK_LOCKED_DOWN = 2'd2
    } lock_e;

    typedef enum logic [1:0] {
        LOP_NONE,
        LOP_LOCK,
        LOP_UNLOCK,
        LOP_LOCKDOWN
    } lock_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE_SETUP,
        ST_LOCK_SETUP,
        ST_ERASING,
        ST_SUSPENDED
    } ctrl_e;

    typedef struct packed {
        logic erase_fail;
        logic seq_fail;
        logic locked_fail;
    } err_t;

    typedef struct packed {
        lock_e lock;
        logic  erased;
    } blk_t;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic       wr_en,
    input  logic [7:0] wr_cmd,
    output cmd_e       kind
);

    always_comb begin
        if (!wr_en) begin
            kind = CMD_NONE;
        end else begin
            unique case (wr_cmd)
                OP_ERASE_SETUP: kind = CMD_ERASE_SETUP;
                OP_CONFIRM:     kind = CMD_CONFIRM;
                OP_SUSPEND:     kind = CMD_SUSPEND;
                OP_LOCK_SETUP:  kind = CMD_LOCK_SETUP;
                OP_LOCK:        kind = CMD_LOCK;
                OP_LOCKDOWN:    kind = CMD_LOCKDOWN;
                OP_CLR_STATUS:  kind = CMD_CLR_STATUS;
                OP_RD_STATUS:   kind = CMD_RD_STATUS;
                OP_RD_ARRAY:    kind = CMD_RD_ARRAY;
                default:        kind = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
    parameter int CYCLES = 64,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    output logic          done,
    output logic [CW-1:0] remaining
);

    logic [CW-1:0] cnt_d, cnt_q;

    assign done      = run && (cnt_q == CW'(1));
    assign remaining = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(CYCLES);
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/flash_blk_table.sv
module flash_blk_table
    import flash_cmd_pkg::*;
#(
    parameter int NUM_BLK = 16,
    localparam int BLK_W = $clog2(NUM_BLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lock_op_e         lock_op,
    input  logic [BLK_W-1:0] op_blk,
    input  logic             mark_erased,
    input  logic [BLK_W-1:0] erased_blk,
    input  logic [BLK_W-1:0] q_blk,
    output lock_e            op_lock,
    output lock_e            q_lock,
    output logic             q_erased
);

    lock_e lock_vec   [NUM_BLK];
    logic  erased_vec [NUM_BLK];

    for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
        blk_t cur_d, cur_q;

        always_comb begin
            cur_d = cur_q;
            if (op_blk == BLK_W'(i) && cur_q.lock != BLK_LOCKED_DOWN) begin
                unique case (lock_op)
                    LOP_LOCK:     cur_d.lock = BLK_LOCKED;
                    LOP_UNLOCK:   cur_d.lock = BLK_UNLOCKED;
                    LOP_LOCKDOWN: cur_d.lock = BLK_LOCKED_DOWN;
                    default:      cur_d.lock = cur_q.lock;
                endcase
            end
            if (mark_erased && erased_blk == BLK_W'(i)) begin
                cur_d.erased = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur_q <= '{lock: BLK_LOCKED, erased: 1'b0};
            end else begin
                cur_q <= cur_d;
            end
        end

        assign lock_vec[i]   = cur_q.lock;
        assign erased_vec[i] = cur_q.erased;
    end

    assign op_lock  = lock_vec[op_blk];
    assign q_lock   = lock_vec[q_blk];
    assign q_erased = erased_vec[q_blk];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int NUM_BLK = 16,
    parameter int ERASE_CYCLES = 64,
    localparam int BLK_W = $clog2(NUM_BLK),
    localparam int CW = $clog2(ERASE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_cmd,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic [BLK_W-1:0] q_blk,
    output logic [7:0]       status,
    output logic             rd_status_mode,
    output logic [1:0]       q_lock,
    output logic             q_erased
);

    typedef struct packed {
        ctrl_e            state;
        logic             rd_status;
        err_t             err;
        logic [BLK_W-1:0] tgt;
    } ctrl_t;

    ctrl_t    r_d, r_q;
    cmd_e     kind;
    lock_op_e lock_op;
    lock_e    op_lock, q_lock_e;
    logic     tmr_load, tmr_run, tmr_done, mark_erased;
    logic [CW-1:0] tmr_left;

    flash_cmd_decode u_dec (
        .wr_en  (wr_en),
        .wr_cmd (wr_cmd),
        .kind   (kind)
    );

    flash_erase_timer #(.CYCLES(ERASE_CYCLES)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tmr_load),
        .run       (tmr_run),
        .done      (tmr_done),
        .remaining (tmr_left)
    );

    flash_blk_table #(.NUM_BLK(NUM_BLK)) u_tab (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_op     (lock_op),
        .op_blk      (wr_blk),
        .mark_erased (mark_erased),
        .erased_blk  (r_q.tgt),
        .q_blk       (q_blk),
        .op_lock     (op_lock),
        .q_lock      (q_lock_e),
        .q_erased    (q_erased)
    );

    always_comb begin
        r_d         = r_q;
        lock_op     = LOP_NONE;
        tmr_load    = 1'b0;
        tmr_run     = 1'b0;
        mark_erased = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                unique case (kind)
                    CMD_ERASE_SETUP: begin
                        r_d.state     = ST_ERASE_SETUP;
                        r_d.rd_status = 1'b1;
                    end
                    CMD_LOCK_SETUP: begin
                        r_d.state     = ST_LOCK_SETUP;
                        r_d.rd_status = 1'b1;
                    end
                    CMD_CLR_STATUS: r_d.err       = '0;
                    CMD_RD_STATUS:  r_d.rd_status = 1'b1;
                    CMD_RD_ARRAY:   r_d.rd_status = 1'b0;
                    default: ;
                endcase
            end

            ST_ERASE_SETUP: begin
                if (kind != CMD_NONE) begin
                    r_d.state     = ST_IDLE;
                    r_d.rd_status = 1'b1;
                    if (kind == CMD_CONFIRM) begin
                        if (op_lock == BLK_UNLOCKED) begin
                            r_d.state = ST_ERASING;
                            r_d.tgt   = wr_blk;
                            tmr_load  = 1'b1;
                        end else begin
                            r_d.err.erase_fail  = 1'b1;
                            r_d.err.locked_fail = 1'b1;
                        end
                    end else begin
                        r_d.err.erase_fail = 1'b1;
                        r_d.err.seq_fail   = 1'b1;
                    end
                end
            end

            ST_LOCK_SETUP: begin
                if (kind != CMD_NONE) begin
                    r_d.state = ST_IDLE;
                    unique case (kind)
                        CMD_LOCK:     lock_op = LOP_LOCK;
                        CMD_CONFIRM:  lock_op = LOP_UNLOCK;
                        CMD_LOCKDOWN: lock_op = LOP_LOCKDOWN;
                        default: begin
                            r_d.err.erase_fail = 1'b1;
                            r_d.err.seq_fail   = 1'b1;
                        end
                    endcase
                end
            end

            ST_ERASING: begin
                tmr_run = (kind != CMD_SUSPEND);
                if (kind == CMD_RD_STATUS) begin
                    r_d.rd_status = 1'b1;
                end
                if (tmr_done) begin
                    r_d.state   = ST_IDLE;
                    mark_erased = 1'b1;
                end else if (kind == CMD_SUSPEND) begin
                    r_d.state = ST_SUSPENDED;
                end
            end

            ST_SUSPENDED: begin
                unique case (kind)
                    CMD_CONFIRM:    r_d.state     = ST_ERASING;
                    CMD_RD_STATUS:  r_d.rd_status = 1'b1;
                    CMD_RD_ARRAY:   r_d.rd_status = 1'b0;
                    CMD_CLR_STATUS: r_d.err       = '0;
                    default: ;
                endcase
            end

            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, rd_status: 1'b0, err: '0, tgt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign status = {r_q.state != ST_ERASING,
                     r_q.state == ST_SUSPENDED,
                     r_q.err.erase_fail,
                     r_q.err.seq_fail,
                     2'b00,
                     r_q.err.locked_fail,
                     1'b0};
    assign rd_status_mode = r_q.rd_status;
    assign q_lock         = q_lock_e;

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
    parameter int NUM_BLK = 16,
    localparam int BLK_W = $clog2(NUM_BLK)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       wr_cmd,
    input logic [BLK_W-1:0] q_blk,
    input logic [7:0]       status,
    input logic             rd_status_mode,
    input logic [1:0]       q_lock
);

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[7]) |-> $past(wr_en && wr_cmd == 8'hD0));

    // R9
    suspend_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> $past(wr_en && wr_cmd == 8'hB0));

    // R9
    suspend_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> status[7]);

    // R3
    lockdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q_lock) == 2'd2 && q_blk == $past(q_blk)) |-> q_lock == 2'd2);

    // R8
    busy_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!status[7]) |-> !$fell(rd_status_mode));

    // R11
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[5]) || $rose(status[4]) || $rose(status[1])) |-> $past(wr_en));

    // R11
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[5]) |-> $past(wr_en && wr_cmd == 8'h50));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.NUM_BLK(NUM_BLK)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_cmd         (wr_cmd),
    .q_blk          (q_blk),
    .status         (status),
    .rd_status_mode (rd_status_mode),
    .q_lock         (q_lock)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;

    localparam int NB   = 8;
    localparam int ECYC = 10;
    localparam int BW   = $clog2(NB);
    localparam int NVEC = 19;

    // row: cmd[21:14] blk[13:11] status[10:3] mode[2] lock[1:0]
    localparam logic [21:0] VEC [NVEC] = '{
        {8'h60, 3'd1, 8'h80, 1'b1, 2'd1},
        {8'hD0, 3'd1, 8'h80, 1'b1, 2'd0},
        {8'h60, 3'd2, 8'h80, 1'b1, 2'd1},
        {8'h2F, 3'd2, 8'h80, 1'b1, 2'd2},
        {8'h60, 3'd2, 8'h80, 1'b1, 2'd2},
        {8'hD0, 3'd2, 8'h80, 1'b1, 2'd2},
        {8'h60, 3'd3, 8'h80, 1'b1, 2'd1},
        {8'h77, 3'd3, 8'hB0, 1'b1, 2'd1},
        {8'h70, 3'd3, 8'hB0, 1'b1, 2'd1},
        {8'h50, 3'd0, 8'h80, 1'b1, 2'd1},
        {8'h20, 3'd4, 8'h80, 1'b1, 2'd1},
        {8'h55, 3'd4, 8'hB0, 1'b1, 2'd1},
        {8'h50, 3'd0, 8'h80, 1'b1, 2'd1},
        {8'hFF, 3'd0, 8'h80, 1'b0, 2'd1},
        {8'h70, 3'd0, 8'h80, 1'b1, 2'd1},
        {8'hB0, 3'd0, 8'h80, 1'b1, 2'd1},
        {8'h20, 3'd0, 8'h80, 1'b1, 2'd1},
        {8'hD0, 3'd2, 8'hA2, 1'b1, 2'd2},
        {8'h50, 3'd0, 8'h80, 1'b1, 2'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_cmd = '0;
    logic [BW-1:0] wr_blk = '0;
    logic [BW-1:0] q_blk = '0;
    logic [7:0]    status;
    logic          rd_status_mode;
    logic [1:0]    q_lock;
    logic          q_erased;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    flash_cmd_ctrl #(.NUM_BLK(NB), .ERASE_CYCLES(ECYC)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_cmd         (wr_cmd),
        .wr_blk         (wr_blk),
        .q_blk          (q_blk),
        .status         (status),
        .rd_status_mode (rd_status_mode),
        .q_lock         (q_lock),
        .q_erased       (q_erased)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] c, input logic [BW-1:0] b);
        @(negedge clk);
        wr_en  = 1'b1;
        wr_cmd = c;
        wr_blk = b;
        @(negedge clk);
        wr_en  = 1'b0;
    endtask

    task automatic qry(input logic [BW-1:0] b);
        q_blk = b;
        #1;
    endtask

    function automatic string req_of(input int i);
        if (i <= 3)  return "R2";
        if (i <= 5)  return "R3";
        if (i <= 7)  return "R4";
        if (i == 8)  return "R11 sticky";
        if (i == 9)  return "R11";
        if (i <= 12) return "R6";
        if (i <= 14) return "R12";
        if (i == 15) return "R14";
        return "R7";
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual still running, expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", 32'(status), 32'h80);
        chk("R1 mode", 32'(rd_status_mode), 32'd0);
        for (int b = 0; b < NB; b++) begin
            qry(BW'(b));
            chk("R1 lock", 32'(q_lock), 32'd1);
            chk("R1 erased", 32'(q_erased), 32'd0);
        end

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            q_blk = VEC[i][13:11];
            do_wr(VEC[i][21:14], VEC[i][13:11]);
            #1;
            chk(req_of(i), 32'(status), 32'(VEC[i][10:3]));
            chk(req_of(i), 32'(rd_status_mode), 32'(VEC[i][2]));
            chk(req_of(i), 32'(q_lock), 32'(VEC[i][1:0]));
        end

        // R5 erase timing, target taken from the confirm write
        do_wr(8'h60, 3'd4); do_wr(8'hD0, 3'd4);
        do_wr(8'h60, 3'd5); do_wr(8'hD0, 3'd5);
        do_wr(8'h20, 3'd4);
        do_wr(8'hD0, 3'd5);
        chk("R5 busy at start", 32'(status), 32'h00);
        repeat (ECYC - 1) @(negedge clk);
        chk("R5 busy last cycle", 32'(status[7]), 32'd0);
        @(negedge clk);
        chk("R5 ready after count", 32'(status), 32'h80);
        qry(3'd5);
        chk("R5 confirm block erased", 32'(q_erased), 32'd1);
        qry(3'd4);
        chk("R5 setup block untouched", 32'(q_erased), 32'd0);

        // R8 commands ignored during erase
        do_wr(8'h20, 3'd4);
        do_wr(8'hD0, 3'd4);
        do_wr(8'h60, 3'd6);
        do_wr(8'hD0, 3'd6);
        do_wr(8'hFF, 3'd0);
        chk("R8 still busy", 32'(status[7]), 32'd0);
        chk("R8 mode kept", 32'(rd_status_mode), 32'd1);
        for (int k = 0; k < 50 && status[7] == 1'b0; k++) @(negedge clk);
        qry(3'd6);
        chk("R8 lock unchanged", 32'(q_lock), 32'd1);
        qry(3'd4);
        chk("R8 erase finished", 32'(q_erased), 32'd1);
        chk("R8 status clean", 32'(status), 32'h80);

        // R9 suspend and R10 resume with frozen count
        do_wr(8'h20, 3'd5);
        do_wr(8'hD0, 3'd5);
        do_wr(8'hB0, 3'd7);
        chk("R9 suspended", 32'(status), 32'hC0);
        repeat (20) @(negedge clk);
        do_wr(8'h20, 3'd0);
        do_wr(8'h60, 3'd0);
        do_wr(8'h01, 3'd0);
        chk("R9 stays suspended", 32'(status), 32'hC0);
        qry(3'd0);
        chk("R9 lock untouched", 32'(q_lock), 32'd1);
        do_wr(8'hD0, 3'd0);
        chk("R10 resumed", 32'(status), 32'h00);
        repeat (ECYC - 2) @(negedge clk);
        chk("R10 busy for remainder", 32'(status[7]), 32'd0);
        @(negedge clk);
        chk("R10 done after remainder", 32'(status), 32'h80);

        // R13 reset during suspend
        do_wr(8'h20, 3'd5);
        do_wr(8'hD0, 3'd5);
        do_wr(8'hB0, 3'd5);
        chk("R13 suspended before reset", 32'(status), 32'hC0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 status", 32'(status), 32'h80);
        chk("R13 mode", 32'(rd_status_mode), 32'd0);
        qry(3'd2);
        chk("R13 lockdown cleared", 32'(q_lock), 32'd1);
        qry(3'd1);
        chk("R13 unlocked block relocked", 32'(q_lock), 32'd1);
        qry(3'd5);
        chk("R13 erased flag cleared", 32'(q_erased), 32'd0);

        finish_run();
    end

endmodule